// File: doc/BRIEF.md
# Transmit/Receive DMA Bus Arbiter

This block decides which of two DMA channels, the receive engine or the transmit engine, drives a single shared bus master port. Each channel raises a request line. The arbiter answers with grant lines, and at most one of them is high. A grant stays with its owner for the whole burst. The owner pulses its own done line to release the bus. Decisions are made only at burst boundaries: when the bus is idle, or in the cycle where the current owner signals done.

A mode input selects one of two policies. In fixed mode, receive always wins a tie. In weighted mode, a programmable ratio gives receive up to k+1 bursts in a row before transmit gets one, where k is the 2-bit weight value. A lone requester is always served at once, whatever the mode.

The controller has three states:
- `ST_IDLE`: no grant.
- `ST_RX`: receive owns the bus.
- `ST_TX`: transmit owns the bus.

Its transitions are:
- `IDLE->RX`, `IDLE->TX` and `IDLE->IDLE`, taken while idle.
- `RX->RX`, `RX->TX` and `RX->IDLE`, taken at an RX burst end.
- `TX->TX`, `TX->RX` and `TX->IDLE`, taken at a TX burst end.
- Hold in `ST_RX` or `ST_TX` while the owner's done is low.

Top module: `dma_bus_arbiter`

## Requirements
- R1: During and right after reset both grants are low, the state is idle and the receive run counter is zero.
- R2: `gnt_rx` and `gnt_tx` are never high in the same cycle.
- R3: From idle, a lone requesting channel is granted on the next clock edge, in either mode.
- R4: A grant stays with its owner until that owner's done is sampled high. New requests and the other channel's done pulse have no effect on it.
- R5: With `arb_mode_rr` = 0 (fixed mode), when both channels request at a boundary, receive is granted.
- R6: With `arb_mode_rr` = 1 (weighted mode), when both request at a boundary, receive is granted if fewer than `rx_weight`+1 receive grants have been counted in a row; otherwise transmit is granted. Weight values 0, 1, 2 and 3 give RX:TX shares of 1:1, 2:1, 3:1 and 4:1.
- R7: The run counter counts every receive grant and saturates at 4. It returns to zero on every transmit grant.
- R8: Any change of `arb_mode_rr` clears the run counter. This clearing takes precedence over a receive grant in the same cycle.
- R9: At a burst end the next grant is issued on the same edge, so bursts can run back to back. If nothing is requesting, both grants drop.
- R10: A channel is granted only at an edge where its request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_mode_rr | input | 1 | 1 = weighted round-robin, 0 = fixed receive priority |
| rx_weight | input | RATIO_W | Receive weight k; receive may take k+1 consecutive grants |
| rx_req | input | 1 | Receive channel requests the bus |
| tx_req | input | 1 | Transmit channel requests the bus |
| rx_done | input | 1 | Receive owner finishes its burst this cycle |
| tx_done | input | 1 | Transmit owner finishes its burst this cycle |
| gnt_rx | output | 1 | Bus granted to receive |
| gnt_tx | output | 1 | Bus granted to transmit |

## Verification
A corrupted run counter cannot be seen while only one channel requests. It shows up at the next boundary where both channels request: transmit receives its grant one or more bursts too early or too late. The bench therefore records the order of grants under sustained contention for every weight. It also records that order after a mode toggle. A wrong state register shows within one cycle, as a grant that does not hold across a burst, a grant that lingers after done, or two grants at once.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RX   = 2'd1,
        ST_TX   = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_RX   = 2'd1,
        PICK_TX   = 2'd2
    } pick_e;

endpackage

// File: rtl/dma_arb_weight.sv
module dma_arb_weight #(
    parameter int RATIO_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_rr,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               rx_win,
    input  logic               tx_win,
    output logic               rx_quota
);
    localparam int MAX_RUN = 1 << RATIO_W;
    localparam int CNT_W   = $clog2(MAX_RUN + 1);

    logic [CNT_W-1:0] run_q;
    logic             mode_q;
    logic [CNT_W-1:0] limit;

    // run of consecutive receive grants; cleared by a transmit grant or a mode change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode_rr;
            if ((mode_rr != mode_q) || tx_win) begin
                run_q <= '0;
            end else if (rx_win && (run_q != CNT_W'(MAX_RUN))) begin
                run_q <= run_q + CNT_W'(1);
            end
        end
    end

    assign limit    = CNT_W'(ratio) + CNT_W'(1);
    assign rx_quota = (run_q < limit);

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
    import dma_arb_pkg::*;
(
    input  logic  rx_req,
    input  logic  tx_req,
    input  logic  mode_rr,
    input  logic  rx_quota,
    output pick_e pick
);
    always_comb begin
        unique case ({rx_req, tx_req})
            2'b00: pick = PICK_NONE;
            2'b10: pick = PICK_RX;
            2'b01: pick = PICK_TX;
            2'b11: begin
                if (!mode_rr)      pick = PICK_RX;
                else if (rx_quota) pick = PICK_RX;
                else               pick = PICK_TX;
            end
            default: pick = PICK_NONE;
        endcase
    end

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
    import dma_arb_pkg::*;
#(
    parameter int RATIO_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arb_mode_rr,
    input  logic [RATIO_W-1:0] rx_weight,
    input  logic               rx_req,
    input  logic               tx_req,
    input  logic               rx_done,
    input  logic               tx_done,
    output logic               gnt_rx,
    output logic               gnt_tx
);
    arb_state_e state_q;
    arb_state_e state_d;
    pick_e      pick;
    logic       boundary;
    logic       rx_quota;
    logic       rx_win;
    logic       tx_win;

    dma_arb_pick u_pick (
        .rx_req   (rx_req),
        .tx_req   (tx_req),
        .mode_rr  (arb_mode_rr),
        .rx_quota (rx_quota),
        .pick     (pick)
    );

    dma_arb_weight #(.RATIO_W(RATIO_W)) u_weight (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_rr  (arb_mode_rr),
        .ratio    (rx_weight),
        .rx_win   (rx_win),
        .tx_win   (tx_win),
        .rx_quota (rx_quota)
    );

    // a decision point: bus idle, or the owner ends its burst now
    always_comb begin
        unique case (state_q)
            ST_IDLE: boundary = 1'b1;
            ST_RX:   boundary = rx_done;
            ST_TX:   boundary = tx_done;
            default: boundary = 1'b1;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (boundary) begin
            unique case (pick)
                PICK_RX: state_d = ST_RX;
                PICK_TX: state_d = ST_TX;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign rx_win = boundary && (pick == PICK_RX);
    assign tx_win = boundary && (pick == PICK_TX);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        gnt_rx = 1'b0;
        gnt_tx = 1'b0;
        unique case (state_q)
            ST_RX:   gnt_rx = 1'b1;
            ST_TX:   gnt_tx = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic arb_mode_rr,
    input logic rx_req,
    input logic tx_req,
    input logic rx_done,
    input logic tx_done,
    input logic gnt_rx,
    input logic gnt_tx
);
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_rx && gnt_tx));

    p_lone_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_rx && !gnt_tx && rx_req && !tx_req) |=> gnt_rx);

    p_lone_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_rx && !gnt_tx && tx_req && !rx_req) |=> gnt_tx);

    p_hold_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_rx && !rx_done) |=> gnt_rx);

    p_hold_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_tx && !tx_done) |=> gnt_tx);

    p_fixed_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!arb_mode_rr && !gnt_rx && !gnt_tx && rx_req && tx_req) |=> gnt_rx);

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (((gnt_rx && rx_done) || (gnt_tx && tx_done)) && !rx_req && !tx_req)
        |=> (!gnt_rx && !gnt_tx));

    p_req_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_rx) |-> $past(rx_req));

    p_req_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_tx) |-> $past(tx_req));

endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk u_chk (.*);

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb;
    localparam int RATIO_W = 2;
    localparam int BURST   = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               arb_mode_rr = 1'b0;
    logic [RATIO_W-1:0] rx_weight = '0;
    logic               gnt_rx, gnt_tx;

    logic auto_on = 1'b0;
    logic rx_req_m = 1'b0, tx_req_m = 1'b0, rx_done_m = 1'b0, tx_done_m = 1'b0;
    logic rx_done_a = 1'b0, tx_done_a = 1'b0;
    int   rx_issued = 0, tx_issued = 0, rx_served = 0, tx_served = 0;
    logic rx_req, tx_req, rx_done, tx_done;

    int   n_cmp = 0, n_bad = 0;
    bit   exp_q[$];   // 1 = RX grant, 0 = TX grant
    bit   finished = 1'b0;

    assign rx_req  = auto_on ? (rx_issued != rx_served) : rx_req_m;
    assign tx_req  = auto_on ? (tx_issued != tx_served) : tx_req_m;
    assign rx_done = auto_on ? rx_done_a : rx_done_m;
    assign tx_done = auto_on ? tx_done_a : tx_done_m;

    always #2 clk = ~clk;

    dma_bus_arbiter #(.RATIO_W(RATIO_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .arb_mode_rr(arb_mode_rr), .rx_weight(rx_weight),
        .rx_req(rx_req), .tx_req(tx_req), .rx_done(rx_done), .tx_done(tx_done),
        .gnt_rx(gnt_rx), .gnt_tx(gnt_tx)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor and channel responders
    logic prev_rx = 1'b0, prev_tx = 1'b0;
    int   rx_beat = 0, tx_beat = 0;
    always @(negedge clk) begin
        if (rst_n) check("R2 one-hot grant", int'(gnt_rx && gnt_tx), 0);
        if (auto_on && rst_n) begin
            if ((gnt_rx && (!prev_rx || rx_done_a)) || (gnt_tx && (!prev_tx || tx_done_a))) begin
                if (exp_q.size() == 0) check("R6 unexpected grant (1=RX)", int'(gnt_rx), 2);
                else check("R6 grant order (1=RX,0=TX)", int'(gnt_rx), int'(exp_q.pop_front()));
            end
            if (rx_done_a) begin rx_done_a = 1'b0; rx_beat = 0; end
            if (tx_done_a) begin tx_done_a = 1'b0; tx_beat = 0; end
            if (gnt_rx) begin
                rx_beat++;
                if (rx_beat == BURST) begin rx_done_a = 1'b1; rx_served++; end
            end
            if (gnt_tx) begin
                tx_beat++;
                if (tx_beat == BURST) begin tx_done_a = 1'b1; tx_served++; end
            end
        end
        prev_rx = gnt_rx;
        prev_tx = gnt_tx;
    end

    // expected grant order derived from R5..R7
    task automatic push_model(input bit rr, input int k, input int na, input int nb);
        int run = 0;
        while (na > 0 || nb > 0) begin
            bit rx_wins;
            if (na > 0 && nb > 0) rx_wins = !rr || (run < k + 1);
            else                  rx_wins = (na > 0);
            exp_q.push_back(rx_wins);
            if (rx_wins) begin na--; if (run < 4) run++; end
            else begin nb--; run = 0; end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic launch(input int na, input int nb);
        @(negedge clk);
        rx_issued += na;
        tx_issued += nb;
    endtask

    task automatic drain(input string tag);
        wait (rx_issued == rx_served && tx_issued == tx_served);
        repeat (4) @(negedge clk);
        check(tag, exp_q.size(), 0);
        check({tag, " bus idle after drain"}, int'(gnt_rx || gnt_tx), 0);
    endtask

    task automatic scenario(input bit rr, input int k, input int na, input int nb, input string tag);
        arb_mode_rr = rr;
        rx_weight   = RATIO_W'(k);
        do_reset();
        push_model(rr, k, na, nb);
        launch(na, nb);
        drain(tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 gnt_rx in reset", int'(gnt_rx), 0);
        check("R1 gnt_tx in reset", int'(gnt_tx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 grants after reset", int'(gnt_rx || gnt_tx), 0);
        repeat (3) @(negedge clk);
        check("R10 no grant without request", int'(gnt_rx || gnt_tx), 0);

        // directed: fixed mode
        rx_req_m = 1'b1; tx_req_m = 1'b1;
        @(negedge clk);
        check("R5 fixed tie goes to RX", int'(gnt_rx), 1);
        check("R5 TX not granted", int'(gnt_tx), 0);
        tx_done_m = 1'b1;
        @(negedge clk);
        tx_done_m = 1'b0;
        check("R4 foreign done ignored, RX holds", int'(gnt_rx), 1);
        @(negedge clk);
        check("R4 RX holds without done", int'(gnt_rx), 1);
        rx_done_m = 1'b1; rx_req_m = 1'b0;
        @(negedge clk);
        rx_done_m = 1'b0;
        check("R9 back-to-back handover to TX", int'(gnt_tx), 1);
        tx_done_m = 1'b1; tx_req_m = 1'b0;
        @(negedge clk);
        tx_done_m = 1'b0;
        check("R9 release to idle", int'(gnt_rx || gnt_tx), 0);
        tx_req_m = 1'b1;
        @(negedge clk);
        check("R3 lone TX granted next edge", int'(gnt_tx), 1);
        rx_req_m = 1'b1;
        @(negedge clk);
        check("R4 RX request does not preempt TX", int'(gnt_tx), 1);
        tx_done_m = 1'b1; tx_req_m = 1'b0; rx_req_m = 1'b0;
        @(negedge clk);
        tx_done_m = 1'b0;
        arb_mode_rr = 1'b1;
        rx_req_m = 1'b1;
        @(negedge clk);
        check("R3 lone RX granted in weighted mode", int'(gnt_rx), 1);
        rx_done_m = 1'b1; rx_req_m = 1'b0;
        @(negedge clk);
        rx_done_m = 1'b0;
        @(negedge clk);

        // scoreboard scenarios
        auto_on = 1'b1;
        scenario(1'b0, 0, 4, 3, "R5 fixed order");
        scenario(1'b1, 0, 3, 3, "R6 weight 1:1");
        scenario(1'b1, 1, 5, 3, "R7 weight 2:1");
        scenario(1'b1, 3, 6, 2, "R6 weight 4:1");
        scenario(1'b1, 2, 2, 4, "R6 weight 3:1 RX runs out");

        // R8: mode toggle clears the run counter
        arb_mode_rr = 1'b1;
        rx_weight   = 2'd3;
        do_reset();
        exp_q.push_back(1'b1);
        exp_q.push_back(1'b1);
        launch(2, 0);
        drain("R8 preload RX run");
        arb_mode_rr = 1'b0;
        repeat (3) @(negedge clk);
        arb_mode_rr = 1'b1;
        repeat (3) @(negedge clk);
        push_model(1'b1, 3, 5, 1);
        launch(5, 1);
        drain("R8 counter cleared by mode change");

        finish_run();
    end

endmodule